// File: doc/BRIEF.md
# Tray Hit-Multiplicity Trigger Encoder

This block turns the discriminator hit lines of one detector tray into a small multiplicity word for a fast trigger. The hit lines are arranged as digitizer boards. Each board carries several front-end groups of eight channels. A group counts as one when any of its channels fired during the crossing. Each board adds up its groups into a short count. The tray level adds the board counts into an unsigned word, and that word is driven as steady logic levels toward the trigger.

Capture is chosen by a configuration input. In the self-timed mode, a free-running window of `CROSS_LEN` local clocks defines each crossing. In the strobe mode, an incoming crossing strobe starts a programmable delay. When the delay ends, the crossing is captured. Every hit input passes through two flip-flops before it is used. Hits are OR-accumulated over the whole crossing, so a pulse of a single sample is not lost. The captured counts move through a registered board stage, a registered pair-sum stage and a registered tray total. The output register holds each value for at least `MIN_HOLD` clocks, which meets the minimum pulse width of the trigger input.

Top module: `tray_mult_enc`

## Requirements
- R1: A group of eight channels adds exactly one to the multiplicity when at least one of its channels is high during the crossing. Otherwise it adds zero. The number of high channels in a group does not change its contribution. Hit bit `b*24 + g*8 + c` is channel c of group g on board b.
- R2: `mult` is the unsigned binary count of contributing groups over the whole tray. It runs from 0 to `NBRD*NGRP`, which is 0 to 24 with the defaults, on a 5-bit port.
- R3: With `strobe_mode` low, crossings are consecutive windows of `CROSS_LEN` clocks that start when reset is released. A hit that is high for even one clock cycle inside a window is counted for that window.
- R4: With `strobe_mode` high, the clock edge that first sees `strobe` high after it was low starts a delay. The data are captured `strobe_phase + 1` edges later. `mult` shows the new value 3 edges after the capture edge, provided the hold window has expired.
- R5: A strobe rising edge that arrives while a strobe-mode capture is still pending is ignored. The pending capture keeps its original timing.
- R6: `mult` changes no more often than once every `MIN_HOLD` clocks. A result that arrives while the hold is running is deferred, and the most recent deferred result is applied on the first edge that the hold allows.
- R7: While `rst` is high, `mult` is 0. It stays 0 after release until the first full crossing has been captured and has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_mode | input | 1 | 0 = self-timed crossing window, 1 = capture from the crossing strobe |
| strobe_phase | input | 3 | Number of extra clocks between the strobe and the capture |
| strobe | input | 1 | Distributed crossing strobe |
| hits | input | NBRD*NGRP*NCH (192) | Discriminator outputs, board-major, then group, then channel |
| mult | output | MW (5) | Held tray multiplicity |

## Verification
A wrong accumulator or group OR shows up at the port as a multiplicity that is off by whole groups. This appears within one crossing plus the three pipeline stages of a steady hit pattern, and sweeping every channel and every group count exposes it. A fault in the strobe delay or in the re-arm guard moves the output transition by at least one clock, and a check that samples the exact edge catches it. A broken hold counter lets `mult` change twice within `MIN_HOLD` clocks, or drops the deferred result, when strobes come two clocks apart.

// File: rtl/tray_mult_enc.sv
module tray_mult_enc #(
  parameter int NBRD      = 8,
  parameter int NGRP      = 3,
  parameter int NCH       = 8,
  parameter int CROSS_LEN = 4,
  parameter int MIN_HOLD  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   strobe_mode,
  input  logic [2:0]                             strobe_phase,
  input  logic                                   strobe,
  input  logic [NBRD*NGRP*NCH-1:0]               hits,
  output logic [$clog2(NBRD*NGRP+1)-1:0]         mult
);
  localparam int NG = NBRD * NGRP;
  localparam int NH = NG * NCH;
  localparam int BW = $clog2(NGRP + 1);
  localparam int MW = $clog2(NG + 1);
  localparam int WW = (CROSS_LEN > 1) ? $clog2(CROSS_LEN) : 1;
  localparam int HW = $clog2(MIN_HOLD + 1);
  localparam int NP = NBRD / 2;

  logic [NH-1:0] s1, s2;
  logic [NG-1:0] acc, grp_now, grp_win;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_now[g] = |s2[g*NCH +: NCH];
  end
  assign grp_win = acc | grp_now;

  logic [WW-1:0] wcnt;
  logic          strb_d, armed, rise, self_evt, st_evt, latch;
  logic [2:0]    dcnt;

  assign rise     = strobe & ~strb_d;
  assign self_evt = !strobe_mode && (wcnt == WW'(CROSS_LEN - 1));
  assign st_evt   = strobe_mode && armed && (dcnt == 3'd0);
  assign latch    = self_evt | st_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; acc <= '0;
      wcnt <= '0; strb_d <= 1'b0; armed <= 1'b0; dcnt <= '0;
    end else begin
      s1  <= hits;
      s2  <= s1;
      acc <= latch ? '0 : grp_win;
      wcnt <= (wcnt == WW'(CROSS_LEN - 1)) ? '0 : wcnt + 1'b1;
      strb_d <= strobe;
      if (armed) begin
        if (dcnt == 3'd0) armed <= 1'b0;
        else dcnt <= dcnt - 3'd1;
      end else if (strobe_mode && rise) begin
        armed <= 1'b1;
        dcnt  <= strobe_phase;
      end
    end
  end

  logic [BW-1:0] bsum [NBRD];
  logic [BW-1:0] bcnt [NBRD];
  logic [MW-1:0] pair [NP];
  logic [MW-1:0] tot, tot_c, pend_val;
  logic          v1, v2, v3, pend, upd;
  logic [HW-1:0] hcnt;

  always_comb begin
    for (int b = 0; b < NBRD; b++) begin
      bsum[b] = '0;
      for (int g = 0; g < NGRP; g++) bsum[b] = bsum[b] + BW'(grp_win[b*NGRP+g]);
    end
    tot_c = '0;
    for (int p = 0; p < NP; p++) tot_c = tot_c + pair[p];
  end

  assign upd = (v3 || pend) && (hcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBRD; b++) bcnt[b] <= '0;
      for (int p = 0; p < NP; p++) pair[p] <= '0;
      tot <= '0; pend_val <= '0; mult <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; pend <= 1'b0; hcnt <= '0;
    end else begin
      v1 <= latch; v2 <= v1; v3 <= v2;
      if (latch) for (int b = 0; b < NBRD; b++) bcnt[b] <= bsum[b];
      if (v1) for (int p = 0; p < NP; p++) pair[p] <= MW'(bcnt[2*p]) + MW'(bcnt[2*p+1]);
      if (v2) tot <= tot_c;
      if (upd) begin
        mult <= v3 ? tot : pend_val;
        pend <= 1'b0;
        hcnt <= HW'(MIN_HOLD - 1);
      end else begin
        if (v3) begin pend <= 1'b1; pend_val <= tot; end
        if (hcnt != '0) hcnt <= hcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tray_mult_enc_chk.sv
module tray_mult_enc_chk #(
  parameter int NG        = 24,
  parameter int CROSS_LEN = 4,
  parameter int MIN_HOLD  = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     strobe_mode,
  input logic                     tok,
  input logic [$clog2(NG+1)-1:0]  mult
);
  localparam int MW = $clog2(NG + 1);
  logic [MW-1:0] prev;
  int unsigned   hgap, wgap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0; hgap <= MIN_HOLD; wgap <= 0; seen <= 1'b0;
    end else begin
      if (mult != prev)
        assert_hold_min_R6: assert (hgap >= MIN_HOLD)
          else $error("mult changed after %0d clocks", hgap);
      if (tok && !strobe_mode && seen)
        assert_window_period_R3: assert (wgap == CROSS_LEN)
          else $error("crossing spacing %0d", wgap);
      prev <= mult;
      hgap <= (mult != prev) ? 1 : ((hgap < MIN_HOLD) ? hgap + 1 : hgap);
      wgap <= tok ? 1 : wgap + 1;
      if (tok) seen <= 1'b1;
    end
  end

  assert_mult_range_R2: assert property (@(posedge clk) disable iff (rst) mult <= MW'(NG));
  assert_reset_zero_R7: assert property (@(posedge clk) rst |=> mult == '0);
endmodule

bind tray_mult_enc tray_mult_enc_chk #(
  .NG(NBRD*NGRP), .CROSS_LEN(CROSS_LEN), .MIN_HOLD(MIN_HOLD)
) u_chk (
  .clk(clk), .rst(rst), .strobe_mode(strobe_mode), .tok(v1), .mult(mult)
);

// File: tb/tray_mult_enc_test.sv
module tray_mult_enc_test;
  localparam int PERIOD = 10;
  localparam int NBRD = 8, NGRP = 3, NCH = 8, CL = 8, MH = 4;
  localparam int NG = NBRD * NGRP, NH = NG * NCH;
  localparam int STEADY = 3 * CL + 6;

  logic clk = 1'b0, rst = 1'b1, mode = 1'b0, strobe = 1'b0;
  logic [2:0] phase = '0;
  logic [NH-1:0] hits = '0;
  logic [4:0] mult;
  int total = 0, bad = 0, bad_gap = 0, gap = 100, last = 0;

  always #(PERIOD/2) clk = ~clk;

  tray_mult_enc #(.NBRD(NBRD), .NGRP(NGRP), .NCH(NCH), .CROSS_LEN(CL), .MIN_HOLD(MH)) uut (
    .clk(clk), .rst(rst), .strobe_mode(mode), .strobe_phase(phase),
    .strobe(strobe), .hits(hits), .mult(mult));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int groups_of(input logic [NH-1:0] h);
    int n = 0;
    for (int g = 0; g < NG; g++) if (|h[g*NCH +: NCH]) n++;
    return n;
  endfunction

  function automatic logic [NH-1:0] first_groups(input int k, input int ch);
    logic [NH-1:0] h = '0;
    for (int g = 0; g < k; g++) h[g*NCH + ((ch + g) % NCH)] = 1'b1;
    return h;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic [2:0] ph);
    @(negedge clk); rst = 1'b1; mode = m; phase = ph; strobe = 1'b0;
    wait_n(3);
    chk("R7 reset", int'(mult), 0);
    rst = 1'b0;
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; @(negedge clk); strobe = 1'b0; @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst) begin gap = 100; last = 0; end
    else if (int'(mult) != last) begin
      if (gap < MH) bad_gap++;
      gap = 1; last = int'(mult);
    end else gap++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen_one, seen_other;
    logic [NH-1:0] a;
    // R7: all hits high, output stays zero until first crossing processed
    hits = '1;
    do_reset(1'b0, 3'd0);
    for (int i = 0; i < CL; i++) begin
      @(negedge clk);
      chk("R7 hold zero after release", int'(mult), 0);
    end
    wait_n(STEADY);
    chk("R2 full tray", int'(mult), NG);

    // R1: every single channel alone counts one
    for (int c = 0; c < NH; c++) begin
      hits = '0; hits[c] = 1'b1;
      wait_n(STEADY);
      chk("R1 single channel", int'(mult), 1);
    end
    // R1: several channels in one group still count one
    hits = '0; hits[4*NCH +: NCH] = '1;
    wait_n(STEADY);
    chk("R1 full group", int'(mult), 1);

    // R2: every count 0..NG
    for (int k = 0; k <= NG; k++) begin
      hits = first_groups(k, k);
      wait_n(STEADY);
      chk("R2 group count", int'(mult), k);
    end
    // R2: pseudo-random sparse patterns
    for (int r = 0; r < 24; r++) begin
      a = '0;
      for (int w = 0; w < NH / 32; w++) a[w*32 +: 32] = $urandom() & $urandom() & $urandom() & $urandom();
      hits = a;
      wait_n(STEADY);
      chk("R2 random pattern", int'(mult), groups_of(a));
    end

    // R3: one-cycle pulse is counted in its window
    hits = '0;
    wait_n(STEADY);
    @(negedge clk); hits[100] = 1'b1;
    @(negedge clk); hits = '0;
    seen_one = 0; seen_other = 0;
    for (int i = 0; i < 3 * CL; i++) begin
      @(negedge clk);
      if (mult == 5'd1) seen_one = 1;
      else if (mult != 5'd0) seen_other = 1;
    end
    chk("R3 short pulse counted", int'(seen_one), 1);
    chk("R3 short pulse no other value", int'(seen_other), 0);
    wait_n(STEADY);
    chk("R3 pulse cleared", int'(mult), 0);

    // R4/R5: strobe mode timing for every phase
    for (int ph = 0; ph < 8; ph++) begin
      int k = ph + 3;
      hits = '0;
      do_reset(1'b1, 3'(ph));
      hits = first_groups(k, ph);
      wait_n(5);
      pulse_strobe(); wait_n(20);
      chk("R4 no capture without strobe edge", int'(mult), k);
      pulse_strobe(); wait_n(20);
      chk("R4 strobe capture value", int'(mult), k);
      hits = '0;
      wait_n(5);
      pulse_strobe(); wait_n(20);
      // timed capture: strobe seen at edge E, output moves at E+4+ph
      strobe = 1'b1; @(negedge clk); strobe = 1'b0;
      if (ph == 7) begin
        @(negedge clk); strobe = 1'b1; @(negedge clk); strobe = 1'b0;
        wait_n(1 + ph);
      end else wait_n(3 + ph);
      chk(ph == 7 ? "R5 rearm ignored, old value" : "R4 old value before edge", int'(mult), k);
      @(negedge clk);
      chk(ph == 7 ? "R5 rearm ignored, new value" : "R4 new value at edge", int'(mult), 0);
    end

    // R6: deferred update under closely spaced strobes
    hits = '0;
    do_reset(1'b1, 3'd0);
    wait_n(20);
    hits = first_groups(5, 1);
    wait_n(6);
    hits = first_groups(11, 2); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    wait_n(2);
    chk("R6 first update", int'(mult), 5);
    wait_n(3);
    chk("R6 held during hold window", int'(mult), 5);
    @(negedge clk);
    chk("R6 deferred update applied", int'(mult), 11);

    // R6: burst of strobes every 2 clocks with changing hits
    for (int i = 0; i < 30; i++) begin
      hits = first_groups(i % (NG + 1), i);
      pulse_strobe();
    end
    hits = first_groups(7, 3);
    wait_n(10);
    pulse_strobe(); wait_n(20);
    pulse_strobe(); wait_n(20);
    chk("R6 settles to last result", int'(mult), 7);
    chk("R6 minimum hold never violated", bad_gap, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule